// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Port Demultiplexer

This block receives 4:2:2 video samples from a pixel input port and separates them into three parallel component streams: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). Each output sample comes with a valid strobe. The input has two formats, chosen by a mode pin. In the narrow format, every component shares one byte lane and arrives one byte per clock. In the wide format, luma uses the low byte lane and chroma uses the high byte lane, and the block loads a word only on every other clock.

Both formats run on the same four-step phase schedule, so the output timing is the same in both. A pulse on the line-start input puts the phase back to its first step, and the byte or word on the port in that cycle is then taken as the first Cb of a pair. The first luma sample of a pair is held until its Cr arrives. It is then presented as one co-sited Y/Cb/Cr triple with a flag that marks it as the even sample. The second luma sample follows on the next cycle, with the chroma pair unchanged. Codes 0 and full-scale are clamped into the legal 1..254 range before output. Downstream filtering and timing-code handling are done elsewhere.

Top module: `ycc_lane_demux`

## Requirements
- R1: While `rst_n` is low, `y_out`, `cb_out`, `cr_out`, `out_valid` and `out_even` are all 0. The block uses a two-stage synchronised reset release, so it accepts input from the third rising edge after `rst_n` rises.
- R2: In narrow mode (`wide_mode`=0), bytes on `pix_in[7:0]` are taken in the order Cb, Y, Cr, Y, and the cycle with `line_start`=1 is the Cb slot. On the edge that captures the Cr byte, the outputs become Y0/Cb/Cr with `out_valid`=1 and `out_even`=1. `pix_in[15:8]` has no effect in this mode.
- R3: On the edge after the triple, the second luma byte appears on `y_out` with `out_valid`=1 and `out_even`=0. `cb_out` and `cr_out` keep the pair.
- R4: In wide mode (`wide_mode`=1), the word is loaded only in the Cb slot and the Cr slot. In the Cb slot, the low lane is Y0 and the high lane is Cb. In the Cr slot, the low lane is Y1 and the high lane is Cr. Words presented in the other two slots have no effect on any output.
- R5: In wide mode, the triple Y0/Cb/Cr is output on the edge that loads the Cr word, with `out_even`=1. Y1 follows on the next edge with `out_even`=0.
- R6: `line_start`=1 aborts any partial group. The sample in that cycle becomes the Cb of a new group, and the following output uses only samples from the new group.
- R7: An input code of 0 is output as 1, and a code of 255 is output as 254, for Y, Cb and Cr.
- R8: `cb_out` and `cr_out` change only in cycles where `out_valid`=1 and `out_even`=1. At all other times every output value is held.
- R9: `out_valid` is 0 after the edges that capture the Cb slot and the first luma slot. It is 1 only after the edges that capture the Cr slot and the last luma slot, which gives two luma samples every four clocks. A group with no line-start pulse follows straight on from the previous one.
- R10: Codes from 1 to 254 pass through to the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0: one byte lane carrying Cb,Y,Cr,Y; 1: luma on low lane, chroma on high lane |
| line_start | input | 1 | Realigns the phase so that the current sample is a Cb slot |
| pix_in | input | 2*DW | Pixel port; low lane [DW-1:0], high lane [2*DW-1:DW] |
| y_out | output | DW | Luma sample |
| cb_out | output | DW | Cb of the current pair |
| cr_out | output | DW | Cr of the current pair |
| out_valid | output | 1 | A new luma sample is on `y_out` |
| out_even | output | 1 | The valid sample is the co-sited (first) luma of a pair |

## Verification
The hardest case to reach from the ports is a partial group cut short by a line-start pulse. In that case a luma byte is already held inside the block and must not leak into the next triple. The stimulus sends a Cb and a Y, pulses line start with new values, and checks that the triple that follows contains only the new group. In wide mode, the words sent in the non-load slots are extreme codes, so any leak would show up clearly on `y_out`.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  // Position within a four-sample 4:2:2 group
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_YA = 2'd1,
    PH_CR = 2'd2,
    PH_YB = 2'd3
  } ph_t;
endpackage

// File: rtl/ycc_rst_sync.sv
module ycc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ycc_phase_ctr.sv
module ycc_phase_ctr
  import ycc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  output ph_t  ph_eff
);
  ph_t ph_q;
  ph_t ph_d;

  always_comb begin
    ph_eff = line_start ? PH_CB : ph_q;
    ph_d   = ph_t'(ph_eff + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_CB;
    else        ph_q <= ph_d;
  end

  // R6: a line-start pulse puts the next slot at the first luma position
  a_r6_realign: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (ph_q == PH_YA));

  // R9: without a pulse the slot advances by one and wraps
  a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> (ph_q == ph_t'($past(ph_q) + 2'd1)));
endmodule

// File: rtl/ycc_capture.sv
module ycc_capture
  import ycc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  ph_t           ph,
  input  logic [2*DW-1:0] pix_in,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          out_valid,
  output logic          out_even
);
  localparam logic [DW-1:0] CODE_LO = DW'(1);
  localparam logic [DW-1:0] CODE_HI = {{(DW-1){1'b1}}, 1'b0};

  function automatic logic [DW-1:0] clamp(input logic [DW-1:0] v);
    if (v < CODE_LO)      return CODE_LO;
    else if (v > CODE_HI) return CODE_HI;
    else                  return v;
  endfunction

  logic [DW-1:0] luma_in, chroma_in;
  logic [DW-1:0] cb_hold_q, cb_hold_d;
  logic [DW-1:0] y_hold_q,  y_hold_d;
  logic [DW-1:0] y_d, cb_d, cr_d;
  logic          valid_d, even_d;
  logic          cb_hold_en, y_hold_en, y_en, pair_en;

  always_comb begin
    luma_in   = clamp(pix_in[DW-1:0]);
    chroma_in = wide_mode ? clamp(pix_in[2*DW-1:DW]) : clamp(pix_in[DW-1:0]);
  end

  // Next-state and enables
  always_comb begin
    cb_hold_en = 1'b0;
    y_hold_en  = 1'b0;
    y_en       = 1'b0;
    pair_en    = 1'b0;
    valid_d    = 1'b0;
    even_d     = 1'b0;
    cb_hold_d  = chroma_in;
    y_hold_d   = luma_in;
    y_d        = luma_in;
    cb_d       = cb_hold_q;
    cr_d       = chroma_in;
    unique case (ph)
      PH_CB: begin
        cb_hold_en = 1'b1;
        y_hold_en  = wide_mode;
      end
      PH_YA: begin
        y_hold_en  = !wide_mode;
      end
      PH_CR: begin
        y_en      = 1'b1;
        y_d       = y_hold_q;
        pair_en   = 1'b1;
        valid_d   = 1'b1;
        even_d    = 1'b1;
        y_hold_en = wide_mode;
      end
      PH_YB: begin
        y_en    = 1'b1;
        y_d     = wide_mode ? y_hold_q : luma_in;
        valid_d = 1'b1;
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_hold_q <= '0;
      y_hold_q  <= '0;
      y_out     <= '0;
      cb_out    <= '0;
      cr_out    <= '0;
      out_valid <= 1'b0;
      out_even  <= 1'b0;
    end else begin
      if (cb_hold_en) cb_hold_q <= cb_hold_d;
      if (y_hold_en)  y_hold_q  <= y_hold_d;
      if (y_en)       y_out     <= y_d;
      if (pair_en) begin
        cb_out <= cb_d;
        cr_out <= cr_d;
      end
      out_valid <= valid_d;
      out_even  <= even_d;
    end
  end

  // R8: chroma pair moves only together with an even-flagged sample
  a_r8_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cb_out) || !$stable(cr_out)) |-> (out_valid && out_even));

  // R7: no out-of-range code reaches a valid output
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (y_out >= CODE_LO && y_out <= CODE_HI &&
                   cb_out >= CODE_LO && cb_out <= CODE_HI &&
                   cr_out >= CODE_LO && cr_out <= CODE_HI));

  // R3: an even sample is followed by its odd partner
  a_r3_odd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_even) |=> (out_valid && !out_even));

  // R9: the slot after the odd sample never carries output
  a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_even) |=> !out_valid);
endmodule

// File: rtl/ycc_lane_demux.sv
module ycc_lane_demux
  import ycc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RST_STAGE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            line_start,
  input  logic [2*DW-1:0] pix_in,
  output logic [DW-1:0]   y_out,
  output logic [DW-1:0]   cb_out,
  output logic [DW-1:0]   cr_out,
  output logic            out_valid,
  output logic            out_even
);
  logic rst_int_n;
  ph_t  ph;

  ycc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ycc_phase_ctr u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .line_start (line_start),
    .ph_eff     (ph)
  );

  ycc_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wide_mode (wide_mode),
    .ph        (ph),
    .pix_in    (pix_in),
    .y_out     (y_out),
    .cb_out    (cb_out),
    .cr_out    (cr_out),
    .out_valid (out_valid),
    .out_even  (out_even)
  );

  // R1: outputs are quiet while the port reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && y_out == '0 && cb_out == '0 && cr_out == '0));
endmodule

// File: tb/tb_ycc_lane_demux.sv
module tb_ycc_lane_demux;
  localparam int DW = 8;

  logic            clk;
  logic            rst_n;
  logic            wide_mode;
  logic            line_start;
  logic [2*DW-1:0] pix_in;
  logic [DW-1:0]   y_out, cb_out, cr_out;
  logic            out_valid, out_even;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ycc_lane_demux #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .line_start(line_start),
    .pix_in(pix_in), .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
    .out_valid(out_valid), .out_even(out_even)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] cl(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : (v == 8'd255) ? 8'd254 : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Present a sample at a falling edge; return after the next falling edge
  task automatic put(input logic [15:0] v, input logic ls);
    pix_in     = v;
    line_start = ls;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic chk_out(input string tag, input int v, input int e,
                         input int y, input int cb, input int cr);
    chk({tag, " valid"}, out_valid, v);
    chk({tag, " even"},  out_even,  e);
    chk({tag, " y"},     y_out,     y);
    chk({tag, " cb"},    cb_out,    cb);
    chk({tag, " cr"},    cr_out,    cr);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wide_mode = 1'b0; line_start = 1'b0; pix_in = '0;
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R2/R3/R9: narrow mode, two back-to-back groups, high lane junk
  task automatic t_narrow();
    wide_mode = 1'b0;
    put(16'hEE20, 1'b1); chk("R9 after cb valid", out_valid, 0);
    put(16'h1150, 1'b0); chk("R9 after y0 valid", out_valid, 0);
    put(16'hFF30, 1'b0); chk_out("R2 triple", 1, 1, 8'h50, 8'h20, 8'h30);
    put(16'h0060, 1'b0); chk_out("R3 odd", 1, 0, 8'h60, 8'h20, 8'h30);
    put(16'h4470, 1'b0); chk_out("R8 hold after cb", 0, 0, 8'h60, 8'h20, 8'h30);
    put(16'h5580, 1'b0); chk_out("R8 hold after y", 0, 0, 8'h60, 8'h20, 8'h30);
    put(16'h6690, 1'b0); chk_out("R9 wrap triple", 1, 1, 8'h80, 8'h70, 8'h90);
    put(16'h77A0, 1'b0); chk_out("R3 wrap odd", 1, 0, 8'hA0, 8'h70, 8'h90);
  endtask

  // R4/R5: wide mode, non-load slots carry extreme junk
  task automatic t_wide();
    wide_mode = 1'b1;
    put({8'h40, 8'h55}, 1'b1); chk("R4 cb slot valid", out_valid, 0);
    put({8'h00, 8'hFF}, 1'b0); chk_out("R4 skip slot", 0, 0, 8'hA0, 8'h70, 8'h90);
    put({8'hC0, 8'h66}, 1'b0); chk_out("R5 triple", 1, 1, 8'h55, 8'h40, 8'hC0);
    put({8'hFF, 8'h00}, 1'b0); chk_out("R5 odd, R4 skip", 1, 0, 8'h66, 8'h40, 8'hC0);
  endtask

  // R6: realign in the middle of a group
  task automatic t_realign();
    wide_mode = 1'b0;
    put(16'h0050, 1'b1);
    put(16'h0060, 1'b0);
    put(16'h0070, 1'b1); chk("R6 new cb no valid", out_valid, 0);
    put(16'h0071, 1'b0); chk("R6 new y no valid", out_valid, 0);
    put(16'h0072, 1'b0); chk_out("R6 triple", 1, 1, 8'h71, 8'h70, 8'h72);
    put(16'h0073, 1'b0); chk_out("R6 odd", 1, 0, 8'h73, 8'h70, 8'h72);
    wide_mode = 1'b1;
    put({8'h21, 8'h31}, 1'b1);
    put({8'h00, 8'h00}, 1'b0);
    put({8'h22, 8'h32}, 1'b1); chk("R6 wide restart", out_valid, 0);
    put({8'hFF, 8'hFF}, 1'b0);
    put({8'h23, 8'h33}, 1'b0); chk_out("R6 wide triple", 1, 1, 8'h32, 8'h22, 8'h23);
    put({8'h00, 8'h00}, 1'b0); chk_out("R6 wide odd", 1, 0, 8'h33, 8'h22, 8'h23);
  endtask

  // R7/R10: clamping and edge-of-range pass-through
  task automatic t_codes();
    wide_mode = 1'b0;
    put(16'h0000, 1'b1); put(16'h00FF, 1'b0); put(16'h00FF, 1'b0);
    chk_out("R7 triple clamp", 1, 1, cl(8'hFF), cl(8'h00), cl(8'hFF));
    put(16'h0000, 1'b0);
    chk("R7 odd clamp", y_out, cl(8'h00));
    put(16'h00FE, 1'b1); put(16'h0001, 1'b0); put(16'h0001, 1'b0);
    chk_out("R10 triple edges", 1, 1, 8'd1, 8'd254, 8'd1);
    put(16'h00FE, 1'b0);
    chk("R10 odd edge", y_out, 254);
    wide_mode = 1'b1;
    put({8'hFF, 8'h00}, 1'b1); put({8'h10, 8'h10}, 1'b0);
    put({8'h00, 8'hFF}, 1'b0);
    chk_out("R7 wide clamp", 1, 1, 8'd1, 8'd254, 8'd1);
    put({8'h10, 8'h10}, 1'b0);
    chk("R7 wide odd clamp", y_out, 254);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_realign();
    t_codes();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule